// File: doc/BRIEF.md
# Bridge Request Gate

This block filters transactions crossing one port of a PCI-style bridge. It holds three enable bits of the bridge's 16-bit command register: the master enable, the memory-space enable and the I/O-space enable. It uses them to decide, for each request, whether the request is forwarded, silently dropped, or answered with an unsupported-request (UR) completion.

Requests travelling upstream, from the secondary side towards the primary side, depend only on the master enable. Requests travelling downstream are decoded against three address windows: a memory window, a prefetchable memory window and an I/O window. The memory-space enable and the I/O-space enable gate these windows. Completions always pass.

A small configuration port writes and reads the command register and the six window bounds. The control is a two-state machine:

- `ST_IDLE` holds `req_ready` high. The transition `accept` (valid and ready) captures the request and moves to `ST_RESP`.
- `ST_RESP` presents exactly one verdict for one cycle. The transition `retire` returns unconditionally to `ST_IDLE`.

Top module: `bridge_req_gate`

## Requirements
- R1: After reset the command register reads 0, `req_ready` is 1 and `dec_valid` is 0.
- R2: A write to offset 04h stores `cfg_wdata[2:0]` into the command register, and the read port shows it from the cycle after the write strobe. Bit 2 is the master enable, bit 1 the memory-space enable and bit 0 the I/O-space enable. Read bits 31:3 at 04h are always 0, and writes to them are ignored.
- R3: The window bounds sit at these offsets and read back as written: memory base at 20h and limit at 24h; prefetchable base at 28h and limit at 2Ch; I/O base at 30h and limit at 34h. Other offsets read 0.
- R4: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On the next cycle `dec_valid` is 1 for exactly one cycle, with exactly one of `dec_fwd`, `dec_drop` or `dec_ur` set, and `req_ready` is 0 in that cycle. Kind codes are: 0 memory read, 1 memory write, 2 MSI, 3 I/O read, 4 I/O write, 5 completion. Codes 6 and 7 are dropped.
- R5: An upstream request (`req_up`=1) of kind 0 to 4 with the master enable clear is rejected. Reads (kinds 0 and 3) get UR. Writes and MSIs (kinds 1, 2 and 4) are dropped.
- R6: An upstream request of kind 0 to 4 with the master enable set is forwarded.
- R7: A completion (kind 5) is forwarded in both directions whatever the command bits are.
- R8: A downstream memory-class request (kinds 0 to 2) is forwarded only when the memory-space enable is set and its address lies in the memory or prefetchable window.
- R9: A downstream I/O request (kinds 3 and 4) is forwarded only when the I/O-space enable is set and its address lies in the I/O window.
- R10: A downstream request that is not forwarded gets UR if it is a read (kinds 0 and 3) and is dropped otherwise.
- R11: An address hits a window when base <= address <= limit, with both bounds included. A window whose limit is below its base matches nothing.
- R12: A verdict uses the register contents present in its decision cycle. A configuration write on the edge that accepts a request applies to that request. A write strobed during the decision cycle does not apply to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | Request kind code |
| req_up | input | 1 | 1 = upstream, 0 = downstream |
| req_addr | input | 32 | Request address |
| dec_valid | output | 1 | Verdict presented this cycle |
| dec_fwd | output | 1 | Verdict: forward |
| dec_drop | output | 1 | Verdict: discard |
| dec_ur | output | 1 | Verdict: answer with unsupported request |

## Verification
A configuration write to the command register and a request decision can fall in the same cycle. The bench provokes this in two ways.

- It strobes a write that sets the master enable on the same edge that accepts an upstream memory write. That request must be forwarded.
- It strobes a write while a verdict is already on the outputs. That verdict must still reflect the old register contents, so a request seen with the master enable clear stays dropped.

Judging both orderings pins down exactly which edge a register update reaches the decision logic.

// File: rtl/brg_gate_pkg.sv
package brg_gate_pkg;
    localparam int CFG_AW = 8;
    localparam int NWIN   = 3;
    localparam int WIN_MEM  = 0;
    localparam int WIN_PREF = 1;
    localparam int WIN_IO   = 2;
    localparam logic [CFG_AW-1:0] OFS_CMD = 8'h04;
    localparam logic [CFG_AW-1:0] OFS_WIN = 8'h20;

    typedef enum logic [2:0] {
        K_MEM_RD = 3'd0,
        K_MEM_WR = 3'd1,
        K_MSI    = 3'd2,
        K_IO_RD  = 3'd3,
        K_IO_WR  = 3'd4,
        K_CPL    = 3'd5
    } req_kind_e;

    typedef enum logic [1:0] {D_NONE, D_FWD, D_DROP, D_UR} verdict_e;

    typedef enum logic {ST_IDLE, ST_RESP} gate_state_e;

    typedef struct packed {
        logic master;
        logic mem;
        logic io;
    } cmd_bits_t;

    function automatic logic [CFG_AW-1:0] win_ofs(int idx, bit is_lim);
        return OFS_WIN + CFG_AW'(idx * 8) + (is_lim ? CFG_AW'(4) : CFG_AW'(0));
    endfunction
endpackage

// File: rtl/brg_gate_cfg.sv
module brg_gate_cfg
    import brg_gate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output logic [DATA_W-1:0]             cfg_rdata,
    output cmd_bits_t                     cmd,
    output logic [NWIN-1:0][ADDR_W-1:0]   win_base,
    output logic [NWIN-1:0][ADDR_W-1:0]   win_lim
);
    cmd_bits_t cmd_q;
    logic      cmd_wr;

    assign cmd_wr = cfg_we && (cfg_addr == OFS_CMD);
    assign cmd    = cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_wr) cmd_q <= cmd_bits_t'(cfg_wdata[2:0]);
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_base[g] <= '0;
                win_lim[g]  <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == win_ofs(g, 1'b0)) win_base[g] <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == win_ofs(g, 1'b1)) win_lim[g]  <= cfg_wdata[ADDR_W-1:0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == OFS_CMD) cfg_rdata = DATA_W'(cmd_q);
        for (int i = 0; i < NWIN; i++) begin
            if (cfg_addr == win_ofs(i, 1'b0)) cfg_rdata = DATA_W'(win_base[i]);
            if (cfg_addr == win_ofs(i, 1'b1)) cfg_rdata = DATA_W'(win_lim[i]);
        end
    end

    // R2: a command write lands on the following cycle
    p_cmd_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (cmd_q == $past(cfg_wdata[2:0])));
    // R2: without a command write, the bits hold
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(cmd_q));
endmodule

// File: rtl/brg_gate_win.sv
module brg_gate_win #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] lim,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    // inclusive bounds; an inverted window can never satisfy both compares
    assign hit = (addr >= base) && (addr <= lim);
endmodule

// File: rtl/brg_gate_fsm.sv
module brg_gate_fsm
    import brg_gate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic              req_up,
    input  logic [ADDR_W-1:0] req_addr,
    input  cmd_bits_t         cmd,
    input  logic [NWIN-1:0]   hit,
    output logic [ADDR_W-1:0] addr_q,
    output logic              dec_valid,
    output logic              dec_fwd,
    output logic              dec_drop,
    output logic              dec_ur
);
    gate_state_e state_q;
    req_kind_e   kind_q;
    logic        up_q;
    verdict_e    verdict;
    logic        is_rd;
    logic        fwd_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_CPL;
            up_q    <= 1'b0;
            addr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    state_q <= ST_RESP;
                    kind_q  <= req_kind_e'(req_kind);
                    up_q    <= req_up;
                    addr_q  <= req_addr;
                end
                ST_RESP: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign dec_valid = (state_q == ST_RESP);

    always_comb begin
        is_rd  = 1'b0;
        fwd_ok = 1'b0;
        unique case (kind_q)
            K_MEM_RD, K_MEM_WR, K_MSI: begin
                is_rd  = (kind_q == K_MEM_RD);
                fwd_ok = up_q ? cmd.master
                              : cmd.mem && (hit[WIN_MEM] || hit[WIN_PREF]);
            end
            K_IO_RD, K_IO_WR: begin
                is_rd  = (kind_q == K_IO_RD);
                fwd_ok = up_q ? cmd.master : cmd.io && hit[WIN_IO];
            end
            K_CPL:   fwd_ok = 1'b1;
            default: fwd_ok = 1'b0;
        endcase
        if (!dec_valid)  verdict = D_NONE;
        else if (fwd_ok) verdict = D_FWD;
        else if (is_rd)  verdict = D_UR;
        else             verdict = D_DROP;
    end

    assign dec_fwd  = (verdict == D_FWD);
    assign dec_drop = (verdict == D_DROP);
    assign dec_ur   = (verdict == D_UR);

    // R4: one verdict per accepted request, on the next cycle
    p_accept_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> dec_valid);
    p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $onehot({dec_fwd, dec_drop, dec_ur}));
    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_fwd || dec_drop || dec_ur));
    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !req_ready);
    // R7: completions are never blocked
    p_cpl_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 3'd5) |=> dec_fwd);
    // R5: without master enable nothing but completions goes upstream
    p_master_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && up_q && kind_q != K_CPL && !cmd.master) |-> !dec_fwd);
endmodule

// File: rtl/bridge_req_gate.sv
module bridge_req_gate
    import brg_gate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic              req_up,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              dec_valid,
    output logic              dec_fwd,
    output logic              dec_drop,
    output logic              dec_ur
);
    cmd_bits_t                   cmd;
    logic [NWIN-1:0][ADDR_W-1:0] win_base;
    logic [NWIN-1:0][ADDR_W-1:0] win_lim;
    logic [NWIN-1:0]             hit;
    logic [ADDR_W-1:0]           addr_q;

    brg_gate_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cmd       (cmd),
        .win_base  (win_base),
        .win_lim   (win_lim)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        brg_gate_win #(.ADDR_W(ADDR_W)) u_win (
            .base (win_base[g]),
            .lim  (win_lim[g]),
            .addr (addr_q),
            .hit  (hit[g])
        );
    end

    brg_gate_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_up    (req_up),
        .req_addr  (req_addr),
        .cmd       (cmd),
        .hit       (hit),
        .addr_q    (addr_q),
        .dec_valid (dec_valid),
        .dec_fwd   (dec_fwd),
        .dec_drop  (dec_drop),
        .dec_ur    (dec_ur)
    );
endmodule

// File: tb/bridge_req_gate_tb.sv
module bridge_req_gate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic        req_up = 1'b0;
    logic [31:0] req_addr = '0;
    logic        dec_valid, dec_fwd, dec_drop, dec_ur;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 0;

    localparam logic [2:0] V_FWD = 3'b100, V_DROP = 3'b010, V_UR = 3'b001;
    localparam logic [2:0] MRD = 3'd0, MWR = 3'd1, MSI = 3'd2,
                           IORD = 3'd3, IOWR = 3'd4, CPL = 3'd5;

    always #5 clk = ~clk;

    bridge_req_gate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_kind(req_kind), .req_up(req_up),
        .req_addr(req_addr), .dec_valid(dec_valid), .dec_fwd(dec_fwd),
        .dec_drop(dec_drop), .dec_ur(dec_ur)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #1 check(tag, cfg_rdata, exp);
    endtask

    // drive one request and judge its verdict in the decision cycle (R4 handshake)
    task automatic send(logic [2:0] k, logic up, logic [31:0] a, logic [2:0] exp, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_up = up; req_addr = a;
        check({tag, " R4 ready"}, {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R4 valid"}, {31'd0, dec_valid}, 32'd1);
        check({tag, " R4 busy"}, {31'd0, req_ready}, 32'd0);
        check(tag, {29'd0, dec_fwd, dec_drop, dec_ur}, {29'd0, exp});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cfg_read(8'h04, 32'h0, "R1 cmd");
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 dec_valid", {31'd0, dec_valid}, 32'd0);
    endtask

    task automatic t_regs();
        cfg_write(8'h04, 32'hFFFF_FFFF);
        cfg_read(8'h04, 32'h7, "R2 upper zero");
        cfg_write(8'h04, 32'h0000_0002);
        cfg_read(8'h04, 32'h2, "R2 mem only");
        cfg_write(8'h20, 32'h0000_1000);
        cfg_write(8'h24, 32'h0000_1FFF);
        cfg_write(8'h28, 32'h0000_8000);
        cfg_write(8'h2C, 32'h0000_8FFF);
        cfg_write(8'h30, 32'h0000_0300);
        cfg_write(8'h34, 32'h0000_03FF);
        cfg_read(8'h20, 32'h1000, "R3 mem base");
        cfg_read(8'h2C, 32'h8FFF, "R3 pref lim");
        cfg_read(8'h34, 32'h03FF, "R3 io lim");
        cfg_read(8'h40, 32'h0, "R3 unmapped");
    endtask

    task automatic t_upstream();
        cfg_write(8'h04, 32'h3);
        send(MRD, 1'b1, 32'h1000, V_UR, "R5 up rd");
        send(MWR, 1'b1, 32'h1000, V_DROP, "R5 up wr");
        send(MSI, 1'b1, 32'hFEE0_0000, V_DROP, "R5 up msi");
        send(IORD, 1'b1, 32'h0300, V_UR, "R5 up io rd");
        cfg_write(8'h04, 32'h4);
        send(MRD, 1'b1, 32'h5, V_FWD, "R6 up rd");
        send(MSI, 1'b1, 32'hFEE0_0000, V_FWD, "R6 up msi");
    endtask

    task automatic t_cpl();
        cfg_write(8'h04, 32'h0);
        send(CPL, 1'b1, 32'h0, V_FWD, "R7 cpl up");
        send(CPL, 1'b0, 32'h9999, V_FWD, "R7 cpl down");
        send(3'd7, 1'b0, 32'h1000, V_DROP, "R4 unknown code");
    endtask

    task automatic t_mem();
        cfg_write(8'h04, 32'h5);
        send(MRD, 1'b0, 32'h1000, V_UR, "R8 mem disabled");
        cfg_write(8'h04, 32'h2);
        send(MRD, 1'b0, 32'h1000, V_FWD, "R11 mem base edge");
        send(MWR, 1'b0, 32'h1FFF, V_FWD, "R11 mem lim edge");
        send(MWR, 1'b0, 32'h2000, V_DROP, "R10 mem miss wr");
        send(MRD, 1'b0, 32'h0FFF, V_UR, "R10 mem miss rd");
        send(MRD, 1'b0, 32'h8800, V_FWD, "R8 pref hit");
        send(IORD, 1'b0, 32'h0300, V_UR, "R9 io off");
    endtask

    task automatic t_io();
        cfg_write(8'h04, 32'h1);
        send(IOWR, 1'b0, 32'h03FF, V_FWD, "R9 io hit");
        send(IORD, 1'b0, 32'h0400, V_UR, "R9 io miss");
        send(MRD, 1'b0, 32'h1000, V_UR, "R8 mem off");
        cfg_write(8'h34, 32'h0000_0100);
        send(IOWR, 1'b0, 32'h0300, V_DROP, "R11 inverted wr");
        send(IORD, 1'b0, 32'h0200, V_UR, "R11 inverted rd");
    endtask

    task automatic t_same_cycle();
        cfg_write(8'h04, 32'h0);
        // write and request on one edge: the new bit governs the verdict
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h04; cfg_wdata = 32'h4;
        req_valid = 1'b1; req_kind = MWR; req_up = 1'b1; req_addr = 32'h10;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R12 write on accept", {29'd0, dec_fwd, dec_drop, dec_ur}, {29'd0, V_FWD});
        cfg_write(8'h04, 32'h0);
        // write strobed in the decision cycle: old bit governs
        @(negedge clk);
        req_valid = 1'b1; req_kind = MWR; req_up = 1'b1; req_addr = 32'h10;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 8'h04; cfg_wdata = 32'h4;
        #1 check("R12 write in decision", {29'd0, dec_fwd, dec_drop, dec_ur}, {29'd0, V_DROP});
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_read(8'h04, 32'h4, "R12 write landed");
    endtask

    initial begin
        t_reset();
        t_regs();
        t_upstream();
        t_cpl();
        t_mem();
        t_io();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule